// File: doc/BRIEF.md
# Sliding-Window Bit-by-Sample Cross-Correlator

This block keeps a matrix of running correlations between a vector of antipodal (±1) decision bits and a vector of signed received samples. Row `i` belongs to bit `i` and column `j` to sample `j`. A bit/sample product needs no multiplier. When the bit is +1 the sample is added. When the bit is −1 the sample is subtracted, using inversion plus a carry into the element adder. Every element of the matrix is updated in parallel on a single strobe.

The block has two modes. In training mode only the newest bit and sample vectors are folded in; these are the known pilot bits and the received pilot signal. In tracking mode the window slides. The product of the oldest bit vector and the oldest sample vector, which are leaving the window, is taken out of every element in the same update that adds the newest product. The window history itself is kept outside the block, and the caller presents the oldest vectors on the ports. Any element can be read at any time through a combinational row/column readout. A done pulse marks the cycle after each update.

Top module: `xcorr_matrix`

## Requirements
- R1: While reset is high and in the cycle after it, every matrix element reads zero and `done_o` is low.
- R2: On a strobe, a new bit of value 1 (meaning +1) adds new sample `j` to element (i,j).
- R3: On a strobe, a new bit of value 0 (meaning −1) subtracts new sample `j` from element (i,j).
- R4: On a strobe with `mode_i` = 1 (tracking), element (i,j) also loses the old product. The old sample `j` is subtracted when old bit `i` is 1 and added when old bit `i` is 0. This happens in the same update.
- R5: With `mode_i` = 0 (training), the old bit and old sample inputs have no effect on any element.
- R6: All elements update on the same strobe. Without a strobe, no element changes, whatever the data inputs do.
- R7: `done_o` is high for exactly the one cycle after each strobe cycle, and low otherwise.
- R8: `rd_data_o` shows element (`rd_row_i`, `rd_col_i`) as a two's-complement value. Sample `j` occupies bits [8j+7:8j] of the sample buses, and bit `i` of a bit bus belongs to row `i`.
- R9: Element width is 8 + log2(window) + 1 bits, so a full window of extreme samples does not wrap. For example, 16 updates of −128 with bit 0 give +2048, and 16 updates of −128 with bit 1 give −2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the matrix |
| upd_i | input | 1 | Update strobe |
| mode_i | input | 1 | 0 = training, 1 = tracking |
| new_bits_i | input | ROWS | Newest bit vector, 1 = +1, 0 = −1 |
| new_samp_i | input | COLS*8 | Newest sample vector, signed 8-bit each |
| old_bits_i | input | ROWS | Oldest windowed bit vector |
| old_samp_i | input | COLS*8 | Oldest windowed sample vector |
| rd_row_i | input | log2(ROWS) | Readout row select |
| rd_col_i | input | log2(COLS) | Readout column select |
| rd_data_o | output | ACC_W | Selected element, signed |
| done_o | output | 1 | One-cycle pulse after each update |

## Verification
Alternating and mixed bit patterns against samples of both signs show whether the sign of each bit is applied to the correct row and the correct sample is used for each column. Training updates with non-zero old inputs, followed by tracking updates with the same old inputs, show whether the removal term depends on the mode and carries its own sign. A run of idle cycles with the data inputs toggling shows that the strobe controls updates. A full window of −128 and +127 samples with fixed bits drives the elements to their extremes, which exposes a narrow accumulator or a missing carry-in.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

    localparam int DEF_ROWS   = 4;
    localparam int DEF_COLS   = 4;
    localparam int DEF_SAMP_W = 8;
    localparam int DEF_WIN    = 16;

    typedef enum logic {
        MODE_TRAIN = 1'b0,
        MODE_TRACK = 1'b1
    } xc_mode_e;

    typedef enum logic {
        POL_ADD    = 1'b0,
        POL_REMOVE = 1'b1
    } xc_pol_e;

    typedef struct packed {
        logic    enable;
        logic    bit_val;
        xc_pol_e pol;
    } term_ctl_t;

    function automatic int acc_width(input int samp_w, input int win);
        return samp_w + $clog2(win) + 1;
    endfunction

    function automatic int sel_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/xc_term.sv
module xc_term
    import xcorr_pkg::*;
#(
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int ACC_W  = acc_width(DEF_SAMP_W, DEF_WIN)
) (
    input  term_ctl_t          ctl_i,
    input  logic [SAMP_W-1:0]  samp_i,
    output logic [ACC_W-1:0]   op_o,
    output logic               cin_o
);

    logic             negate;
    logic [ACC_W-1:0] sx;

    always_comb begin
        sx = {{(ACC_W-SAMP_W){samp_i[SAMP_W-1]}}, samp_i};
        if (ctl_i.pol == POL_ADD)
            negate = ~ctl_i.bit_val;
        else
            negate = ctl_i.bit_val;
        if (ctl_i.enable) begin
            op_o  = sx ^ {ACC_W{negate}};
            cin_o = negate;
        end else begin
            op_o  = '0;
            cin_o = 1'b0;
        end
    end

endmodule

// File: rtl/xc_cell.sv
module xc_cell
    import xcorr_pkg::*;
#(
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int ACC_W  = acc_width(DEF_SAMP_W, DEF_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_i,
    input  xc_mode_e          mode_i,
    input  logic              new_bit_i,
    input  logic [SAMP_W-1:0] new_samp_i,
    input  logic              old_bit_i,
    input  logic [SAMP_W-1:0] old_samp_i,
    output logic [ACC_W-1:0]  acc_o
);

    term_ctl_t        add_ctl, rem_ctl;
    logic [ACC_W-1:0] add_op, rem_op, acc_q, acc_d;
    logic             add_cin, rem_cin;

    always_comb begin
        add_ctl.enable  = 1'b1;
        add_ctl.bit_val = new_bit_i;
        add_ctl.pol     = POL_ADD;
        rem_ctl.enable  = (mode_i == MODE_TRACK);
        rem_ctl.bit_val = old_bit_i;
        rem_ctl.pol     = POL_REMOVE;
    end

    xc_term #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_add (
        .ctl_i (add_ctl),
        .samp_i(new_samp_i),
        .op_o  (add_op),
        .cin_o (add_cin)
    );

    xc_term #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_rem (
        .ctl_i (rem_ctl),
        .samp_i(old_samp_i),
        .op_o  (rem_op),
        .cin_o (rem_cin)
    );

    always_comb begin
        acc_d = acc_q + add_op + rem_op
              + {{(ACC_W-1){1'b0}}, add_cin}
              + {{(ACC_W-1){1'b0}}, rem_cin};
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (upd_i)
            acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    // Wide shadow sum built from the raw inputs, used only to guard range
    logic signed [ACC_W+1:0] wide_sum;
    logic signed [ACC_W+1:0] add_w, rem_w;
    always_comb begin
        add_w = new_bit_i ? (ACC_W+2)'($signed(new_samp_i))
                          : -(ACC_W+2)'($signed(new_samp_i));
        rem_w = (mode_i != MODE_TRACK) ? '0 :
                (old_bit_i ? -(ACC_W+2)'($signed(old_samp_i))
                           : (ACC_W+2)'($signed(old_samp_i)));
        wide_sum = (ACC_W+2)'($signed(acc_q)) + add_w + rem_w;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        upd_i |-> (wide_sum[ACC_W+1:ACC_W-1] == '0 || wide_sum[ACC_W+1:ACC_W-1] == '1)); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(acc_o)); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_o == '0)); // R1

endmodule

// File: rtl/xc_readout.sv
module xc_readout
    import xcorr_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int COLS  = DEF_COLS,
    parameter int ACC_W = acc_width(DEF_SAMP_W, DEF_WIN),
    localparam int ROW_W = sel_width(ROWS),
    localparam int COL_W = sel_width(COLS)
) (
    input  logic [ROWS*COLS*ACC_W-1:0] mat_i,
    input  logic [ROW_W-1:0]           row_i,
    input  logic [COL_W-1:0]           col_i,
    output logic [ACC_W-1:0]           data_o
);

    int idx;

    always_comb begin
        idx    = int'(row_i) * COLS + int'(col_i);
        data_o = '0;
        for (int k = 0; k < ROWS*COLS; k++) begin
            if (k == idx)
                data_o = mat_i[k*ACC_W +: ACC_W];
        end
    end

endmodule

// File: rtl/xcorr_matrix.sv
module xcorr_matrix
    import xcorr_pkg::*;
#(
    parameter int ROWS   = DEF_ROWS,
    parameter int COLS   = DEF_COLS,
    parameter int SAMP_W = DEF_SAMP_W,
    parameter int WIN    = DEF_WIN,
    localparam int ACC_W = acc_width(SAMP_W, WIN),
    localparam int ROW_W = sel_width(ROWS),
    localparam int COL_W = sel_width(COLS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd_i,
    input  logic                   mode_i,
    input  logic [ROWS-1:0]        new_bits_i,
    input  logic [COLS*SAMP_W-1:0] new_samp_i,
    input  logic [ROWS-1:0]        old_bits_i,
    input  logic [COLS*SAMP_W-1:0] old_samp_i,
    input  logic [ROW_W-1:0]       rd_row_i,
    input  logic [COL_W-1:0]       rd_col_i,
    output logic [ACC_W-1:0]       rd_data_o,
    output logic                   done_o
);

    xc_mode_e                   mode;
    logic [ROWS*COLS*ACC_W-1:0] mat;
    logic                       done_q;

    assign mode = xc_mode_e'(mode_i);

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            xc_cell #(.SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_cell (
                .clk       (clk),
                .rst       (rst),
                .upd_i     (upd_i),
                .mode_i    (mode),
                .new_bit_i (new_bits_i[i]),
                .new_samp_i(new_samp_i[j*SAMP_W +: SAMP_W]),
                .old_bit_i (old_bits_i[i]),
                .old_samp_i(old_samp_i[j*SAMP_W +: SAMP_W]),
                .acc_o     (mat[(i*COLS+j)*ACC_W +: ACC_W])
            );
        end
    end

    xc_readout #(.ROWS(ROWS), .COLS(COLS), .ACC_W(ACC_W)) u_rd (
        .mat_i (mat),
        .row_i (rd_row_i),
        .col_i (rd_col_i),
        .data_o(rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            done_q <= 1'b0;
        else
            done_q <= upd_i;
    end

    assign done_o = done_q;

    AST_DONE_AFTER_UPD: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> done_o); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> !done_o); // R7

endmodule

// File: tb/sim_xcorr_matrix.sv
`timescale 1ns/1ps
module sim_xcorr_matrix;

    localparam int NR = 4;
    localparam int NC = 4;
    localparam int SW = 8;
    localparam int WL = 16;
    localparam int AW = SW + $clog2(WL) + 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              upd = 1'b0;
    logic              mode = 1'b0;
    logic [NR-1:0]     nb = '0, ob = '0;
    logic [NC*SW-1:0]  ns = '0, os = '0;
    logic [1:0]        rr = '0, rc = '0;
    logic [AW-1:0]     rd;
    logic              done;

    int checks = 0;
    int errors = 0;
    int exp_m [NR][NC];
    bit finished = 0;

    always #10 clk = ~clk;

    xcorr_matrix u0 (
        .clk(clk), .rst(rst), .upd_i(upd), .mode_i(mode),
        .new_bits_i(nb), .new_samp_i(ns),
        .old_bits_i(ob), .old_samp_i(os),
        .rd_row_i(rr), .rd_col_i(rc),
        .rd_data_o(rd), .done_o(done)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_matrix(input string req);
        for (int i = 0; i < NR; i++) begin
            for (int j = 0; j < NC; j++) begin
                rr = 2'(i); rc = 2'(j);
                #1;
                chk(req, int'($signed(rd)), exp_m[i][j]);
            end
        end
    endtask

    function automatic int sval(input logic [NC*SW-1:0] v, input int j);
        return int'($signed(v[j*SW +: SW]));
    endfunction

    task automatic model_update(input logic [NR-1:0] b, input logic [NC*SW-1:0] s,
                                input logic [NR-1:0] b_o, input logic [NC*SW-1:0] s_o,
                                input logic trk);
        for (int i = 0; i < NR; i++)
            for (int j = 0; j < NC; j++) begin
                exp_m[i][j] += b[i] ? sval(s, j) : -sval(s, j);
                if (trk) exp_m[i][j] -= b_o[i] ? sval(s_o, j) : -sval(s_o, j);
            end
    endtask

    // One strobe; checks done timing (R7) and full matrix
    task automatic apply(input logic [NR-1:0] b, input logic [NC*SW-1:0] s,
                         input logic [NR-1:0] b_o, input logic [NC*SW-1:0] s_o,
                         input logic trk, input string req, input bit full_chk);
        @(negedge clk);
        nb = b; ns = s; ob = b_o; os = s_o; mode = trk; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        chk("R7 done high", int'(done), 1);
        model_update(b, s, b_o, s_o, trk);
        if (full_chk) check_matrix(req);
        @(negedge clk);
        chk("R7 done low", int'(done), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1; upd = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NR; i++) for (int j = 0; j < NC; j++) exp_m[i][j] = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 done", int'(done), 0);
        check_matrix("R1 reset zero");
    endtask

    task automatic t_train_mix();
        // bits 1,0,1,0 with samples 5,-7,100,-128 ; old inputs non-zero (R5)
        apply(4'b0101, {8'sh80, 8'sd100, 8'shF9, 8'sd5}, 4'b1111, {4{8'sd33}}, 1'b0,
              "R2 R3 R5 training", 1);
        apply(4'b1100, {8'sd1, 8'sd127, 8'sd2, 8'shFF}, 4'b0000, {4{8'sh90}}, 1'b0,
              "R2 R3 R5 second", 1);
    endtask

    task automatic t_idle();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            nb = 4'(k * 5); ns = {4{8'(k * 37)}}; mode = k[0];
        end
        @(negedge clk);
        chk("R7 idle done", int'(done), 0);
        check_matrix("R6 no strobe hold");
    endtask

    task automatic t_track();
        apply(4'b1010, {8'sd9, 8'shF0, 8'sd50, 8'sd3}, 4'b0110, {8'sd4, 8'shEC, 8'sd11, 8'sh81}, 1'b1,
              "R4 tracking removal", 1);
        apply(4'b0011, {8'sd0, 8'sd1, 8'shFF, 8'sd64}, 4'b1001, {8'sd127, 8'sd0, 8'shC0, 8'sd7}, 1'b1,
              "R4 tracking second", 1);
    endtask

    task automatic t_back_to_back();
        // consecutive strobes: done stays high
        @(negedge clk);
        nb = 4'b1111; ns = {4{8'sd10}}; mode = 1'b0; upd = 1'b1;
        @(negedge clk);
        nb = 4'b0000; ns = {4{8'sd3}};
        model_update(4'b1111, {4{8'sd10}}, '0, '0, 1'b0);
        chk("R7 b2b first", int'(done), 1);
        @(negedge clk);
        upd = 1'b0;
        model_update(4'b0000, {4{8'sd3}}, '0, '0, 1'b0);
        chk("R7 b2b second", int'(done), 1);
        check_matrix("R6 b2b matrix");
    endtask

    task automatic t_full_window();
        do_reset();
        for (int k = 0; k < WL; k++)
            apply(4'b1010, {8'sh80, 8'sd127, 8'sh80, 8'sd127}, '0, '0, 1'b0, "R9", 0);
        rr = 2'd1; rc = 2'd1; #1;
        chk("R9 +1 x -128 window", int'($signed(rd)), -2048);
        rr = 2'd0; rc = 2'd1; #1;
        chk("R9 -1 x -128 window", int'($signed(rd)), 2048);
        rr = 2'd3; rc = 2'd0; #1;
        chk("R8 R9 row3 col0", int'($signed(rd)), 2032);
        check_matrix("R9 full window");
    endtask

    initial begin
        t_reset();
        t_train_mix();
        t_idle();
        t_track();
        t_back_to_back();
        t_full_window();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #4000000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule